// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Engine

This block moves a device's byte stream to or from system memory by following a table of scatter/gather descriptors that the host places in memory. The host writes the table's byte address into a pointer register, then writes the command register with the start bit set and the direction bit chosen. The engine fetches each 8-byte descriptor through a single-beat memory master and copies bytes one at a time between the described buffer and the device stream. When the table or the device runs out, it reports the outcome in a status register and raises an interrupt.

The engine compares the table's total length with the number of bytes the device actually delivers. Three outcomes leave three different status patterns. If the table runs out at the same moment as the device, the interrupt bit is set and the active bit is clear. If the device finishes while the table still has room, both bits are set and the engine halts until the host stops it. If the table runs out while the device still has data, the status is zero. The host can clear the start bit at any time to abandon the transfer.

Top module: `bmd_engine`

## Requirements
- R1: The host port decodes three offsets. Offset 0 is the command register: bit 0 is start and bit 3 is the direction, where 1 means device to memory. Offset 2 is the status register: bit 0 is active, bit 1 is error and bit 2 is interrupt. Offset 4 is the 32-bit table pointer. After reset, all three read zero and `irq` is low.
- R2: A command write with bit 0 set while active is clear sets active. The engine then fetches each descriptor as two 32-bit little-endian reads at the entry address and at the entry address plus 4. Word 0 is the buffer byte address. Word 1 bits [15:0] are the byte count and bit 31 marks the last entry. Entries follow one another every 8 bytes.
- R3: A descriptor byte count of zero moves 65536 bytes.
- R4: The direction bit selects the copy. With direction 1, bytes taken from `dev_in` are written to consecutive addresses of each buffer, in table order. With direction 0, bytes read from consecutive buffer addresses are presented on `dev_out` in the same order.
- R5: If `dev_done` arrives and the final byte of the last entry is moved, with no room left in the table, the status reads 0x04 and `irq` is high.
- R6: If the device finishes while the table still has room, no further byte moves. The status reads 0x05 and `irq` is high.
- R7: If the last entry is used up before `dev_done`, the status reads 0x00 and the engine accepts no further device bytes.
- R8: A command write with bit 0 clear while active is set stops the engine at once and clears active. The interrupt bit keeps its value, so a stop after an R6 halt leaves 0x04 and a stop during a transfer leaves 0x00.
- R9: Writing status with bit 2 set clears the interrupt bit. Writing status with bit 2 clear leaves it unchanged. `irq` always equals status bit 2, and the error bit reads 0.
- R10: Writes to the table pointer are ignored while active is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a write |
| mem_wide | output | 1 | 1: 32-bit word access, 0: single byte in lane 0 |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data (byte in bits [7:0]) |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current request |
| dev_in_valid | input | 1 | Device offers a byte (device-to-memory) |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_ready | output | 1 | Engine takes the offered byte |
| dev_out_valid | output | 1 | Engine offers a byte (memory-to-device) |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device takes the offered byte |
| dev_done | input | 1 | Device has delivered or accepted its last byte |
| irq | output | 1 | Interrupt, mirrors status bit 2 |

## Verification
The assertions assume that the table pointer is a multiple of 8, so descriptor reads are word aligned. They also assume that `dev_done` is raised no later than the cycle of the device's final byte handshake, and that the memory returns `mem_ack` for every request the engine holds. The bench keeps to these rules in three ways. It places every table at an aligned address. Its device model raises `dev_done` in exactly the cycle of its last handshake. Its memory model acknowledges each request in the cycle it is made. Stop commands are issued only by host writes at the falling edge, so they never overlap a reset.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;
   localparam logic [2:0] OFS_PTR  = 3'd4;

   localparam int CMD_GO_BIT   = 0;
   localparam int CMD_DIR_BIT  = 3;
   localparam int STAT_ACT_BIT = 0;
   localparam int STAT_ERR_BIT = 1;
   localparam int STAT_IRQ_BIT = 2;

   localparam int DESC_BYTES = 8;
   localparam int LAST_BIT   = 31;

   typedef enum logic [2:0] {
      W_IDLE,
      W_DESC_A,
      W_DESC_B,
      W_PULL,
      W_PUSH,
      W_HALT
   } walk_e;

endpackage

// File: rtl/bmd_regs.sv
module bmd_regs
   import bmd_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          ev_exact,
   input  logic          ev_long,
   input  logic          ev_short,
   output logic          go,
   output logic          go_to_mem,
   output logic          abort,
   output logic          active,
   output logic          irq,
   output logic [AW-1:0] tbl_ptr
);

   logic wr_cmd, wr_stat, wr_ptr;
   logic start_q, dir_q, intr_q, act_q;
   logic [AW-1:0] ptr_q;

   assign wr_cmd  = reg_we && (reg_addr == OFS_CMD);
   assign wr_stat = reg_we && (reg_addr == OFS_STAT);
   assign wr_ptr  = reg_we && (reg_addr == OFS_PTR);

   assign go        = wr_cmd &&  reg_wdata[CMD_GO_BIT] && !act_q;
   assign abort     = wr_cmd && !reg_wdata[CMD_GO_BIT] &&  act_q;
   assign go_to_mem = reg_wdata[CMD_DIR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         dir_q   <= 1'b0;
         intr_q  <= 1'b0;
         act_q   <= 1'b0;
         ptr_q   <= '0;
      end else begin
         if (wr_cmd) begin
            start_q <= reg_wdata[CMD_GO_BIT];
            dir_q   <= reg_wdata[CMD_DIR_BIT];
         end
         if (go)
            act_q <= 1'b1;
         else if (abort || ev_exact || ev_short)
            act_q <= 1'b0;
         if (ev_exact || ev_long)
            intr_q <= 1'b1;
         else if (wr_stat && reg_wdata[STAT_IRQ_BIT])
            intr_q <= 1'b0;
         if (wr_ptr && !act_q)
            ptr_q <= reg_wdata[AW-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_CMD: begin
            reg_rdata[CMD_GO_BIT]  = start_q;
            reg_rdata[CMD_DIR_BIT] = dir_q;
         end
         OFS_STAT: begin
            reg_rdata[STAT_ACT_BIT] = act_q;
            reg_rdata[STAT_ERR_BIT] = 1'b0;
            reg_rdata[STAT_IRQ_BIT] = intr_q;
         end
         OFS_PTR:  reg_rdata[AW-1:0] = ptr_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign active  = act_q;
   assign irq     = intr_q;
   assign tbl_ptr = ptr_q;

endmodule

// File: rtl/bmd_walker.sv
module bmd_walker
   import bmd_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CNT_W     = 16,
   parameter bit ZERO_FULL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          go_to_mem,
   input  logic          abort,
   input  logic [AW-1:0] tbl_ptr,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_wide,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_ack,
   input  logic          dev_in_valid,
   input  logic [7:0]    dev_in_data,
   output logic          dev_in_ready,
   output logic          dev_out_valid,
   output logic [7:0]    dev_out_data,
   input  logic          dev_out_ready,
   input  logic          dev_done,
   output logic          ev_exact,
   output logic          ev_long,
   output logic          ev_short
);

   localparam int REM_W = CNT_W + 1;

   walk_e           st, nxt;
   logic [AW-1:0]   cur, buf_addr;
   logic [REM_W-1:0] rem, span;
   logic            last_q, dev_fin, to_mem;
   logic [7:0]      hold;
   logic            take_a, take_b, take_pull, step;
   logic            boundary, bnd_last, fin;

   generate
      if (ZERO_FULL) begin : g_zero_full
         assign span = (mem_rdata[CNT_W-1:0] == '0) ? (REM_W'(1) << CNT_W)
                                                    : {1'b0, mem_rdata[CNT_W-1:0]};
      end else begin : g_zero_lit
         assign span = {1'b0, mem_rdata[CNT_W-1:0]};
      end
   endgenerate

   assign fin = dev_fin || dev_done;

   always_comb begin
      nxt           = st;
      ev_exact      = 1'b0;
      ev_long       = 1'b0;
      ev_short      = 1'b0;
      mem_req       = 1'b0;
      mem_we        = 1'b0;
      mem_wide      = 1'b0;
      mem_addr      = buf_addr;
      mem_wdata     = {24'b0, hold};
      dev_in_ready  = 1'b0;
      dev_out_valid = 1'b0;
      dev_out_data  = hold;
      take_a        = 1'b0;
      take_b        = 1'b0;
      take_pull     = 1'b0;
      step          = 1'b0;
      boundary      = 1'b0;
      bnd_last      = 1'b0;
      unique case (st)
         W_IDLE: if (go) nxt = W_DESC_A;
         W_DESC_A: begin
            if (dev_fin) begin
               nxt     = W_HALT;
               ev_long = 1'b1;
            end else begin
               mem_req  = 1'b1;
               mem_wide = 1'b1;
               mem_addr = cur;
               if (mem_ack) begin
                  take_a = 1'b1;
                  nxt    = W_DESC_B;
               end
            end
         end
         W_DESC_B: begin
            mem_req  = 1'b1;
            mem_wide = 1'b1;
            mem_addr = cur + AW'(4);
            if (mem_ack) begin
               take_b = 1'b1;
               if (span == '0) begin
                  boundary = 1'b1;
                  bnd_last = mem_rdata[LAST_BIT];
               end else begin
                  nxt = W_PULL;
               end
            end
         end
         W_PULL: begin
            if (dev_fin) begin
               nxt     = W_HALT;
               ev_long = 1'b1;
            end else if (to_mem) begin
               dev_in_ready = 1'b1;
               if (dev_in_valid) begin
                  take_pull = 1'b1;
                  nxt       = W_PUSH;
               end
            end else begin
               mem_req = 1'b1;
               if (mem_ack) begin
                  take_pull = 1'b1;
                  nxt       = W_PUSH;
               end
            end
         end
         W_PUSH: begin
            if (to_mem) begin
               mem_req = 1'b1;
               mem_we  = 1'b1;
               step    = mem_ack;
            end else begin
               dev_out_valid = 1'b1;
               step          = dev_out_ready;
            end
            if (step) begin
               if (rem == REM_W'(1)) begin
                  boundary = 1'b1;
                  bnd_last = last_q;
               end else begin
                  nxt = W_PULL;
               end
            end
         end
         W_HALT: nxt = W_HALT;
         default: nxt = W_IDLE;
      endcase
      if (boundary) begin
         if (!bnd_last) begin
            nxt = W_DESC_A;
         end else if (fin) begin
            nxt      = W_IDLE;
            ev_exact = 1'b1;
         end else begin
            nxt      = W_IDLE;
            ev_short = 1'b1;
         end
      end
      if (abort) nxt = W_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= W_IDLE;
         cur      <= '0;
         buf_addr <= '0;
         rem      <= '0;
         last_q   <= 1'b0;
         dev_fin  <= 1'b0;
         to_mem   <= 1'b0;
         hold     <= '0;
      end else begin
         st <= nxt;
         if (st == W_IDLE && go) begin
            cur    <= tbl_ptr;
            to_mem <= go_to_mem;
         end
         if (take_a) buf_addr <= mem_rdata[AW-1:0];
         if (take_b) begin
            rem    <= span;
            last_q <= mem_rdata[LAST_BIT];
            cur    <= cur + AW'(DESC_BYTES);
         end
         if (take_pull) hold <= to_mem ? dev_in_data : mem_rdata[7:0];
         if (step) begin
            buf_addr <= buf_addr + AW'(1);
            rem      <= rem - REM_W'(1);
         end
         if (go || abort)
            dev_fin <= 1'b0;
         else if (st != W_IDLE && dev_done)
            dev_fin <= 1'b1;
      end
   end

endmodule

// File: rtl/bmd_engine.sv
module bmd_engine
   import bmd_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CNT_W     = 16,
   parameter bit ZERO_FULL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_wide,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_ack,
   input  logic          dev_in_valid,
   input  logic [7:0]    dev_in_data,
   output logic          dev_in_ready,
   output logic          dev_out_valid,
   output logic [7:0]    dev_out_data,
   input  logic          dev_out_ready,
   input  logic          dev_done,
   output logic          irq
);

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("bmd_engine: AW must lie in 8..32");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt
         $error("bmd_engine: CNT_W must lie in 1..31");
      end
   endgenerate

   logic          go, go_to_mem, abort, active;
   logic          ev_exact, ev_long, ev_short;
   logic [AW-1:0] tbl_ptr;

   bmd_regs #(.AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ev_exact  (ev_exact),
      .ev_long   (ev_long),
      .ev_short  (ev_short),
      .go        (go),
      .go_to_mem (go_to_mem),
      .abort     (abort),
      .active    (active),
      .irq       (irq),
      .tbl_ptr   (tbl_ptr)
   );

   bmd_walker #(.AW(AW), .CNT_W(CNT_W), .ZERO_FULL(ZERO_FULL)) u_walk (
      .clk           (clk),
      .rst_n         (rst_n),
      .go            (go),
      .go_to_mem     (go_to_mem),
      .abort         (abort),
      .tbl_ptr       (tbl_ptr),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_wide      (mem_wide),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .mem_rdata     (mem_rdata),
      .mem_ack       (mem_ack),
      .dev_in_valid  (dev_in_valid),
      .dev_in_data   (dev_in_data),
      .dev_in_ready  (dev_in_ready),
      .dev_out_valid (dev_out_valid),
      .dev_out_data  (dev_out_data),
      .dev_out_ready (dev_out_ready),
      .dev_done      (dev_done),
      .ev_exact      (ev_exact),
      .ev_long       (ev_long),
      .ev_short      (ev_short)
   );

endmodule

// File: rtl/bmd_engine_chk.sv
module bmd_engine_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [2:0]    reg_addr,
   input logic [31:0]   reg_wdata,
   input logic          mem_req,
   input logic          mem_wide,
   input logic [AW-1:0] mem_addr,
   input logic          dev_in_ready,
   input logic          dev_out_valid,
   input logic          irq,
   input logic          active,
   input logic [AW-1:0] tbl_ptr,
   input logic          ev_exact,
   input logic          ev_long
);

   logic stop_wr;
   assign stop_wr = reg_we && reg_addr == 3'd0 && !reg_wdata[0];

   a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (active && reg_we && reg_addr == 3'd4) |=> $stable(tbl_ptr));

   a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd2 && reg_wdata[2] && !ev_exact && !ev_long) |=> !irq);

   a_r2_desc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_wide) |-> (mem_addr[1:0] == 2'b00));

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!mem_req && !dev_in_ready && !dev_out_valid));

   a_r5_exact_status: assert property (@(posedge clk) disable iff (!rst_n)
      ev_exact |=> (irq && !active));

   a_r6_long_status: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_long && !stop_wr) |=> (irq && active));

   a_r4_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_in_ready && dev_out_valid));

endmodule

bind bmd_engine bmd_engine_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_addr      (reg_addr),
   .reg_wdata     (reg_wdata),
   .mem_req       (mem_req),
   .mem_wide      (mem_wide),
   .mem_addr      (mem_addr),
   .dev_in_ready  (dev_in_ready),
   .dev_out_valid (dev_out_valid),
   .irq           (irq),
   .active        (active),
   .tbl_ptr       (tbl_ptr),
   .ev_exact      (ev_exact),
   .ev_long       (ev_long)
);

// File: tb/tb_bmd_engine.sv
module tb_bmd_engine;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_req, mem_we, mem_wide, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          dev_in_valid = 1'b0;
   logic [7:0]    dev_in_data = '0;
   logic          dev_in_ready;
   logic          dev_out_valid;
   logic [7:0]    dev_out_data;
   logic          dev_out_ready = 1'b0;
   logic          dev_done = 1'b0;
   logic          irq;

   int errors = 0;
   int checks = 0;
   logic dev_stop = 1'b0;
   int   dev_count;
   logic [7:0] rx [256];
   logic [7:0] m [1024];

   always #5 clk = ~clk;

   bmd_engine dut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
      .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
      .dev_done(dev_done), .irq(irq)
   );

   // memory model: acknowledges in the cycle of the request
   assign mem_ack   = mem_req;
   assign mem_rdata = mem_wide ? {m[mem_addr[9:0] + 10'd3], m[mem_addr[9:0] + 10'd2],
                                  m[mem_addr[9:0] + 10'd1], m[mem_addr[9:0]]}
                               : {24'b0, m[mem_addr[9:0]]};
   always @(posedge clk)
      if (mem_req && mem_we && mem_ack) m[mem_addr[9:0]] <= mem_wdata[7:0];

   typedef struct packed {
      logic        to_mem;
      logic [15:0] dev_len;
      logic [15:0] e0;
      logic [15:0] e1;
      logic        two;
      logic [7:0]  exp_stat;
      logic [15:0] exp_moved;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'd16, 16'd16, 16'd0, 1'b0, 8'h04, 16'd16},  // R5 exact, device to memory
      '{1'b1, 16'd16, 16'd8,  16'd8, 1'b1, 8'h04, 16'd16},  // R2 two entries
      '{1'b1, 16'd16, 16'd8,  16'd0, 1'b0, 8'h00, 16'd8},   // R7 short table
      '{1'b1, 16'd8,  16'd32, 16'd0, 1'b0, 8'h05, 16'd8},   // R6 long table
      '{1'b0, 16'd12, 16'd12, 16'd0, 1'b0, 8'h04, 16'd12},  // R4 memory to device, exact
      '{1'b0, 16'd12, 16'd4,  16'd4, 1'b1, 8'h00, 16'd8},   // R7 short, two entries
      '{1'b0, 16'd5,  16'd10, 16'd0, 1'b0, 8'h05, 16'd5},   // R6 long, memory to device
      '{1'b1, 16'd10, 16'd0,  16'd0, 1'b0, 8'h05, 16'd10}   // R3 zero count
   };

   function automatic logic [7:0] pat(int k, int seed);
      return 8'(k * 13 + seed * 29 + 7);
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic put32(int a, logic [31:0] v);
      for (int b = 0; b < 4; b++) m[a + b] = v[8*b +: 8];
   endtask

   task automatic device(logic to_mem, int n, int seed);
      dev_count = 0;
      while (dev_count < n && !dev_stop) begin
         @(negedge clk);
         dev_done = 1'b0;
         if (to_mem) begin
            dev_in_valid = 1'b1;
            dev_in_data  = pat(dev_count, seed);
            #1;
            if (dev_in_ready) begin
               dev_count++;
               if (dev_count == n) dev_done = 1'b1;
            end
         end else begin
            dev_out_ready = 1'b1;
            #1;
            if (dev_out_valid) begin
               rx[dev_count[7:0]] = dev_out_data;
               dev_count++;
               if (dev_count == n) dev_done = 1'b1;
            end
         end
      end
      @(negedge clk);
      dev_in_valid  = 1'b0;
      dev_out_ready = 1'b0;
      dev_done      = 1'b0;
   endtask

   task automatic wait_end(output logic [31:0] st);
      st = '0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         #2;
         rd(3'd2, st);
         if (!st[0] || st[2]) break;
      end
   endtask

   task automatic build(vec_t v, int seed);
      int e0c;
      e0c = (v.e0 == 16'd0) ? 65536 : int'(v.e0);
      for (int a = 16'h200; a < 16'h300; a++) m[a] = 8'h00;
      put32(16'h100, 32'h200);
      put32(16'h104, {~v.two, 15'b0, v.e0});
      put32(16'h108, 32'h280);
      put32(16'h10C, {1'b1, 15'b0, v.e1});
      if (!v.to_mem)
         for (int k = 0; k < 128; k++) begin
            if (k < e0c) m[16'h200 + k] = pat(k, seed);
            else         m[16'h280 + k - e0c] = pat(k, seed);
         end
   endtask

   task automatic run_vec(int idx);
      vec_t v;
      logic [31:0] st;
      int e0c, bad, a;
      v = VECS[idx];
      e0c = (v.e0 == 16'd0) ? 65536 : int'(v.e0);
      build(v, idx);
      dev_stop = 1'b0;
      fork
         device(v.to_mem, int'(v.dev_len), idx);
         begin
            wr(3'd4, 32'h100);
            wr(3'd0, {28'b0, v.to_mem, 3'b001});
            wait_end(st);
            repeat (3) @(negedge clk);
            dev_stop = 1'b1;
         end
      join
      rd(3'd2, st);
      chk($sformatf("R5/R6/R7 vec%0d status", idx), int'(st[7:0]), int'(v.exp_stat));
      chk($sformatf("R9 vec%0d irq mirrors bit 2", idx), int'(irq), int'(v.exp_stat[2]));
      chk($sformatf("R4 vec%0d bytes moved", idx), dev_count, int'(v.exp_moved));
      bad = 0;
      for (int k = 0; k < int'(v.exp_moved); k++) begin
         a = (k < e0c) ? 16'h200 + k : 16'h280 + k - e0c;
         if (v.to_mem) begin
            if (m[a] !== pat(k, idx)) bad++;
         end else begin
            if (rx[k] !== pat(k, idx)) bad++;
         end
      end
      chk($sformatf("R2/R4 vec%0d data mismatches", idx), bad, 0);
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] st;
      for (int a = 0; a < 1024; a++) m[a] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, st); chk("R1 command after reset", int'(st), 0);
      rd(3'd2, st); chk("R1 status after reset", int'(st), 0);
      rd(3'd4, st); chk("R1 pointer after reset", int'(st), 0);
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 no memory request after reset", int'(mem_req), 0);
      wr(3'd4, 32'h0000_0108);
      rd(3'd4, st); chk("R1 pointer readback", int'(st), 32'h108);

      for (int i = 0; i < NV; i++) run_vec(i);

      // R9 write-one-to-clear behaviour after an exact completion
      build(VECS[0], 0);
      dev_stop = 1'b0;
      fork
         device(1'b1, 16, 0);
         begin
            wr(3'd4, 32'h100);
            wr(3'd0, 32'h9);
            wait_end(st);
            repeat (3) @(negedge clk);
            dev_stop = 1'b1;
         end
      join
      rd(3'd0, st); chk("R1 command readback start and direction", int'(st), 9);
      wr(3'd2, 32'h0);
      rd(3'd2, st); chk("R9 zero write keeps interrupt", int'(st), 4);
      wr(3'd2, 32'h4);
      rd(3'd2, st); chk("R9 one write clears interrupt", int'(st), 0);
      chk("R9 irq low after clear", int'(irq), 0);
      wr(3'd0, 32'h0);

      // R10 pointer write ignored while halted active, then R8 stop after halt
      build(VECS[3], 3);
      dev_stop = 1'b0;
      fork
         device(1'b1, 8, 3);
         begin
            wr(3'd4, 32'h100);
            wr(3'd0, 32'h9);
            wait_end(st);
            repeat (3) @(negedge clk);
            dev_stop = 1'b1;
         end
      join
      wr(3'd4, 32'h3F8);
      rd(3'd4, st); chk("R10 pointer unchanged while active", int'(st), 32'h100);
      wr(3'd0, 32'h8);
      rd(3'd2, st); chk("R8 stop after halt leaves interrupt only", int'(st), 4);
      wr(3'd2, 32'h4);

      // R8 stop in the middle of a transfer
      begin
         vec_t v;
         v = VECS[0];
         v.e0 = 16'd40;
         v.dev_len = 16'd40;
         build(v, 9);
      end
      dev_stop = 1'b0;
      fork
         device(1'b1, 40, 9);
         begin
            wr(3'd4, 32'h100);
            wr(3'd0, 32'h9);
            repeat (6) @(negedge clk);
            wr(3'd0, 32'h8);
            #2;
            rd(3'd2, st); chk("R8 stop mid-transfer status", int'(st), 0);
            chk("R8 no memory request after stop", int'(mem_req), 0);
            chk("R7 no device byte taken after stop", int'(dev_in_ready), 0);
            dev_stop = 1'b1;
         end
      join
      rd(3'd4, st); chk("R10 pointer writable when idle", int'(st), 32'h100);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule